// File: doc/BRIEF.md
# Suspend Clock-Stop Resume Sequencer

This block runs CPU suspend entry and exit for a processor that supports a suspend request and acknowledge handshake. An 8-bit control register selects one of two suspend depths. In the light depth only the CPU is halted and the system clocks keep running. In the full depth the system clock-stop output is also asserted. The upper four bits of the register hold a settle time for the clock generator and the PLLs, in milliseconds, from 0 to 15. Bits 3:1 are reserved and always read as zero.

A suspend command pulse captures the depth and the settle time, then raises the CPU suspend request. When the acknowledge arrives, the sequencer either holds the CPU halted (light) or also stops the system clocks (full). A break event wakes the system. In the light depth the suspend request drops at once. In the full depth the clock-stop output is released first, the block counts the programmed number of millisecond tick pulses, and only then is the suspend request released. A break that arrives before the acknowledge is remembered and acted on once the acknowledge has been seen.

States: ST_IDLE (nothing asserted), ST_HANDSHAKE (request raised, waiting for the acknowledge, break latched), ST_HALT (light suspend), ST_CLKSTOP (full suspend, clocks stopped) and ST_SETTLE (clocks running again, settle timer counting). Transitions:
- ST_IDLE to ST_HANDSHAKE on a suspend command.
- ST_HANDSHAKE to ST_HALT on the acknowledge with the light depth captured.
- ST_HANDSHAKE to ST_CLKSTOP on the acknowledge with the full depth captured.
- ST_HALT to ST_IDLE on a break or a latched break.
- ST_CLKSTOP to ST_SETTLE on a break or a latched break.
- ST_SETTLE to ST_IDLE when the counted ticks equal the captured settle time.

Top module: `clkstop_resume_seq`

## Requirements
- R1: After reset, cfg_rdata is 00h and both cpu_susp_req and sys_clk_stop are low.
- R2: A cycle with cfg_we high stores cfg_wdata bits 7:4 (settle time) and bit 0 (full-depth enable). From the next cycle cfg_rdata shows them, with bits 3:1 always 0, so cfg_rdata equals cfg_wdata AND F1h.
- R3: A susp_cmd pulse sampled in ST_IDLE raises cpu_susp_req from the next cycle. sys_clk_stop stays low while the acknowledge is awaited.
- R4: With bit 0 captured as 0, cpu_susp_req stays high and sys_clk_stop stays low after the acknowledge. A brk_evt sampled in ST_HALT drops cpu_susp_req on the next cycle.
- R5: With bit 0 captured as 1, sys_clk_stop rises on the cycle after susp_ack is sampled high in ST_HANDSHAKE, and never before. It is high only while cpu_susp_req is high.
- R6: A brk_evt sampled in ST_CLKSTOP drops sys_clk_stop on the next cycle while cpu_susp_req stays high.
- R7: In ST_SETTLE, cpu_susp_req stays high until N ms_tick pulses have been sampled, where N is the captured settle time. It drops one cycle after the cycle in which the count reaches N. With N = 0 it drops on the cycle after sys_clk_stop drops.
- R8: The depth bit and the settle time are captured when the suspend command is accepted. A register write during a suspend does not change the sequence in progress.
- R9: A brk_evt sampled in ST_HANDSHAKE is latched. After the acknowledge, the light depth drops cpu_susp_req two cycles after the acknowledge is sampled. The full depth shows sys_clk_stop for one cycle and then enters ST_SETTLE.
- R10: These have no effect: a susp_cmd outside ST_IDLE, a brk_evt in ST_IDLE, and ms_tick pulses outside ST_SETTLE (they do not shorten the settle time).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register contents |
| susp_cmd | input | 1 | Suspend command pulse |
| susp_ack | input | 1 | CPU suspend acknowledge |
| brk_evt | input | 1 | Break / resume event pulse |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| cpu_susp_req | output | 1 | Suspend request to the CPU |
| sys_clk_stop | output | 1 | System clock-stop request |

## Verification
The hardest situation to reach is a wake-up that overlaps the other events. Cases include a break latched before the acknowledge, ticks that arrive while the clocks are still stopped, and a register rewrite during the settle phase. Directed sequences set up each of these on purpose: a break is pulsed ahead of the acknowledge, ticks are sent during ST_CLKSTOP, and the register is rewritten mid-suspend. A long stretch of random commands, acknowledges, breaks, ticks and register writes follows, and on every clock it is compared with a behavioural model that keeps a countdown of the remaining milliseconds.

// File: rtl/scs_pkg.sv
package scs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HANDSHAKE,
        ST_HALT,
        ST_CLKSTOP,
        ST_SETTLE
    } scs_state_e;
endpackage

// File: rtl/scs_ctrl_reg.sv
module scs_ctrl_reg #(
    parameter int CFG_W   = 8,
    parameter int DLY_W   = 4,
    parameter int DLY_LSB = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] q,
    output logic [DLY_W-1:0] dly,
    output logic             stop_en
);
    // bit 0 and the delay field are storage; every other bit is reserved, reads 0 (R2)
    for (genvar i = 0; i < CFG_W; i++) begin : g_bit
        if (i == 0 || (i >= DLY_LSB && i < DLY_LSB + DLY_W)) begin : g_store
            logic bit_q;
            always_ff @(posedge clk) begin
                if (!rst_n)  bit_q <= 1'b0;
                else if (we) bit_q <= wdata[i];
            end
            assign q[i] = bit_q;
        end else begin : g_rsvd
            assign q[i] = 1'b0;
        end
    end

    assign dly     = q[DLY_LSB +: DLY_W];
    assign stop_en = q[0];
endmodule

// File: rtl/scs_settle_timer.sv
module scs_settle_timer #(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [DLY_W-1:0] dly_in,
    input  logic             run,
    input  logic             tick,
    output logic             done
);
    logic [DLY_W-1:0] target_q;
    logic [DLY_W-1:0] cnt_q;

    assign done = (cnt_q == target_q);

    // target captured at suspend acceptance (R8); ticks counted only while running (R7, R10)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q <= '0;
            cnt_q    <= '0;
        end else if (arm) begin
            target_q <= dly_in;
            cnt_q    <= '0;
        end else if (run && tick && !done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/scs_fsm.sv
module scs_fsm
    import scs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic susp_cmd,
    input  logic susp_ack,
    input  logic brk_evt,
    input  logic stop_en,
    input  logic timer_done,
    output logic arm,
    output logic settle_run,
    output logic cpu_susp_req,
    output logic sys_clk_stop
);
    scs_state_e state_q, state_d;
    logic       full_q;
    logic       pend_q;
    logic       wake;

    assign wake       = brk_evt | pend_q;
    assign arm        = (state_q == ST_IDLE) && susp_cmd;
    assign settle_run = (state_q == ST_SETTLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (susp_cmd)  state_d = ST_HANDSHAKE;
            ST_HANDSHAKE: if (susp_ack)  state_d = full_q ? ST_CLKSTOP : ST_HALT;
            ST_HALT:      if (wake)      state_d = ST_IDLE;
            ST_CLKSTOP:   if (wake)      state_d = ST_SETTLE;
            ST_SETTLE:    if (timer_done) state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            full_q  <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (arm) full_q <= stop_en;
            if (state_q == ST_IDLE)                      pend_q <= 1'b0;
            else if (state_q == ST_HANDSHAKE && brk_evt) pend_q <= 1'b1;
        end
    end

    always_comb begin
        cpu_susp_req = 1'b0;
        sys_clk_stop = 1'b0;
        unique case (state_q)
            ST_IDLE:      ;
            ST_HANDSHAKE: cpu_susp_req = 1'b1;
            ST_HALT:      cpu_susp_req = 1'b1;
            ST_CLKSTOP: begin
                cpu_susp_req = 1'b1;
                sys_clk_stop = 1'b1;
            end
            ST_SETTLE:    cpu_susp_req = 1'b1;
            default:      ;
        endcase
    end
endmodule

// File: rtl/clkstop_resume_seq.sv
module clkstop_resume_seq #(
    parameter int CFG_W = 8,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             susp_cmd,
    input  logic             susp_ack,
    input  logic             brk_evt,
    input  logic             ms_tick,
    output logic             cpu_susp_req,
    output logic             sys_clk_stop
);
    localparam int DLY_LSB = CFG_W - DLY_W;

    logic [DLY_W-1:0] dly;
    logic             stop_en;
    logic             arm;
    logic             settle_run;
    logic             timer_done;

    scs_ctrl_reg #(.CFG_W(CFG_W), .DLY_W(DLY_W), .DLY_LSB(DLY_LSB)) u_reg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .q(cfg_rdata), .dly(dly), .stop_en(stop_en)
    );

    scs_settle_timer #(.DLY_W(DLY_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .arm(arm), .dly_in(dly),
        .run(settle_run), .tick(ms_tick), .done(timer_done)
    );

    scs_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .susp_cmd(susp_cmd), .susp_ack(susp_ack),
        .brk_evt(brk_evt), .stop_en(stop_en), .timer_done(timer_done),
        .arm(arm), .settle_run(settle_run),
        .cpu_susp_req(cpu_susp_req), .sys_clk_stop(sys_clk_stop)
    );
endmodule

// File: rtl/scs_chk.sv
module scs_chk #(
    parameter int CFG_W = 8,
    parameter int DLY_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             susp_cmd,
    input logic             susp_ack,
    input logic             cpu_susp_req,
    input logic             sys_clk_stop
);
    localparam logic [CFG_W-1:0] WMASK =
        CFG_W'(((1 << DLY_W) - 1) << (CFG_W - DLY_W)) | CFG_W'(1);

    p_rdata_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata == ($past(cfg_wdata) & WMASK)));

    p_req_after_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_susp_req) |-> $past(susp_cmd));

    p_stop_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_clk_stop) |-> $past(susp_ack));

    p_stop_inside_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sys_clk_stop |-> cpu_susp_req);

    p_release_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_clk_stop) |-> cpu_susp_req);
endmodule

bind clkstop_resume_seq scs_chk #(.CFG_W(CFG_W), .DLY_W(DLY_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .susp_cmd(susp_cmd), .susp_ack(susp_ack),
    .cpu_susp_req(cpu_susp_req), .sys_clk_stop(sys_clk_stop)
);

// File: tb/sim_clkstop_resume_seq.sv
`timescale 1ns/1ps
module sim_clkstop_resume_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       susp_cmd = 1'b0;
    logic       susp_ack = 1'b0;
    logic       brk_evt = 1'b0;
    logic       ms_tick = 1'b0;
    logic       cpu_susp_req;
    logic       sys_clk_stop;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    clkstop_resume_seq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .susp_cmd(susp_cmd), .susp_ack(susp_ack),
        .brk_evt(brk_evt), .ms_tick(ms_tick),
        .cpu_susp_req(cpu_susp_req), .sys_clk_stop(sys_clk_stop)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference: phase names, remembered wake, countdown of ms left
    localparam int P_OFF = 0, P_WAIT = 1, P_CPU = 2, P_DEEP = 3, P_WARM = 4;
    int   m_phase = P_OFF;
    int   m_left  = 0;
    int   m_dly   = 0;
    bit   m_deep  = 1'b0;
    bit   m_wake  = 1'b0;
    logic [7:0] m_reg = 8'h00;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = P_OFF; m_reg = 8'h00; m_wake = 1'b0; m_left = 0;
        end else begin
            case (m_phase)
                P_OFF: if (susp_cmd) begin
                    m_deep = m_reg[0]; m_dly = int'(m_reg[7:4]);
                    m_wake = 1'b0; m_phase = P_WAIT;
                end
                P_WAIT: begin
                    if (brk_evt) m_wake = 1'b1;
                    if (susp_ack) m_phase = m_deep ? P_DEEP : P_CPU;
                end
                P_CPU:  if (brk_evt || m_wake) m_phase = P_OFF;
                P_DEEP: if (brk_evt || m_wake) begin m_phase = P_WARM; m_left = m_dly; end
                P_WARM: if (m_left == 0) m_phase = P_OFF;
                        else if (ms_tick) m_left--;
                default: m_phase = P_OFF;
            endcase
            if (cfg_we) m_reg = cfg_wdata & 8'hF1;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            chk("R3 R4 R7 R9 R10 cpu_susp_req vs model", {7'd0, cpu_susp_req},
                {7'd0, m_phase != P_OFF});
            chk("R5 R6 R9 sys_clk_stop vs model", {7'd0, sys_clk_stop},
                {7'd0, m_phase == P_DEEP});
            chk("R1 R2 cfg_rdata vs model", cfg_rdata, m_reg);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1; step(1); s = 1'b0;
    endtask

    task automatic wr(input logic [7:0] v);
        cfg_wdata = v; cfg_we = 1'b1; step(1); cfg_we = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        step(3);
        chk("R1 reset rdata", cfg_rdata, 8'h00);
        chk("R1 reset req", {7'd0, cpu_susp_req}, 8'h00);
        chk("R1 reset stop", {7'd0, sys_clk_stop}, 8'h00);
        rst_n = 1'b1;
        step(1);

        wr(8'hFF);
        chk("R2 reserved bits read 0", cfg_rdata, 8'hF1);

        // light suspend
        wr(8'h30);
        pulse(brk_evt); step(1);
        chk("R10 break in idle ignored", {7'd0, cpu_susp_req}, 8'h00);
        pulse(susp_cmd);
        chk("R3 req up after cmd", {7'd0, cpu_susp_req}, 8'h01);
        chk("R3 no stop while waiting", {7'd0, sys_clk_stop}, 8'h00);
        step(3);
        pulse(susp_ack); step(2);
        chk("R4 light: req held", {7'd0, cpu_susp_req}, 8'h01);
        chk("R4 light: no stop", {7'd0, sys_clk_stop}, 8'h00);
        pulse(brk_evt);
        chk("R4 light: break releases", {7'd0, cpu_susp_req}, 8'h00);

        // full suspend, 3 ms
        wr(8'h31);
        pulse(susp_cmd);
        pulse(susp_ack);
        chk("R5 stop after ack", {7'd0, sys_clk_stop}, 8'h01);
        wr(8'h00);
        pulse(susp_cmd);
        chk("R10 cmd while busy ignored", {7'd0, sys_clk_stop}, 8'h01);
        pulse(ms_tick); pulse(ms_tick); pulse(ms_tick); pulse(ms_tick);
        pulse(brk_evt);
        chk("R6 stop released first", {7'd0, sys_clk_stop}, 8'h00);
        chk("R6 req still held", {7'd0, cpu_susp_req}, 8'h01);
        pulse(ms_tick); step(1); pulse(ms_tick); step(2);
        chk("R10 early ticks not counted", {7'd0, cpu_susp_req}, 8'h01);
        pulse(ms_tick);
        chk("R7 R8 req after third tick", {7'd0, cpu_susp_req}, 8'h01);
        step(1);
        chk("R7 R8 req released after 3 ms", {7'd0, cpu_susp_req}, 8'h00);

        // full suspend, zero delay
        wr(8'h01);
        pulse(susp_cmd); pulse(susp_ack); pulse(brk_evt);
        chk("R7 zero delay: stop low", {7'd0, sys_clk_stop}, 8'h00);
        chk("R7 zero delay: req high", {7'd0, cpu_susp_req}, 8'h01);
        step(1);
        chk("R7 zero delay: req low next", {7'd0, cpu_susp_req}, 8'h00);

        // latched break, full depth, 5 ms
        wr(8'h51);
        pulse(susp_cmd); pulse(brk_evt); step(3);
        chk("R9 latched break waits for ack", {7'd0, cpu_susp_req}, 8'h01);
        pulse(susp_ack);
        chk("R9 stop shows one cycle", {7'd0, sys_clk_stop}, 8'h01);
        step(1);
        chk("R9 then settle", {7'd0, sys_clk_stop}, 8'h00);
        for (int i = 0; i < 5; i++) begin pulse(ms_tick); step(1); end
        step(1);
        chk("R7 R9 released after 5 ms", {7'd0, cpu_susp_req}, 8'h00);

        // latched break, light depth
        wr(8'h00);
        pulse(susp_cmd); pulse(brk_evt); pulse(susp_ack);
        chk("R9 light one cycle after ack", {7'd0, cpu_susp_req}, 8'h01);
        step(1);
        chk("R9 light released", {7'd0, cpu_susp_req}, 8'h00);

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            cfg_we    = ($urandom_range(0, 15) == 0);
            cfg_wdata = 8'($urandom);
            susp_cmd  = ($urandom_range(0, 5) == 0);
            susp_ack  = ($urandom_range(0, 2) == 0);
            brk_evt   = ($urandom_range(0, 7) == 0);
            ms_tick   = ($urandom_range(0, 2) == 0);
            step(1);
        end
        cfg_we = 0; susp_cmd = 0; susp_ack = 0; brk_evt = 0; ms_tick = 0;
        step(2);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule